// File: doc/BRIEF.md
# Overlay Pixel Decoder and Compositor

This block sits at the end of an on-screen overlay path. It receives one raw overlay buffer word per beat, together with the background video pixel that the word is to cover. It decodes the word into an 8-bit-per-channel colour and an alpha value, then blends the result over the background. The format of the word depends on two settings: a container size (8, 16 or 32 bits per pixel) and a colour format (indexed, 5-6-5, 5-5-5 with a spare bit, 4-4-4 with a spare nibble, or 8-8-8-8 with alpha). Indexed pixels look up a 256-entry palette held inside the block.

Three sources of transparency can act on the same pixel, and each can be enabled separately: a per-pixel local alpha whose meaning depends on the format, a single global alpha, and a colour key that makes a matching pixel fully transparent. Software loads a palette entry in two writes. The first write loads the entry index and the second writes the 32-bit colour. Pixels flow through a three-stage pipeline with valid/ready handshaking on both sides. When the output is back-pressured, the whole pipeline stalls.

The configuration inputs are expected to stay constant while pixels are in flight. Palette writes are expected not to coincide with pixel traffic.

Top module: `osd_compositor`

## Requirements
- R1: During and directly after reset, out_valid is low and in_ready is high.
- R2: Asserting pal_idx_we loads pal_wdata[7:0] as the palette index. A later pal_data_we stores the whole pal_wdata at that index. The entry layout is alpha [31:24], red [23:16], green [15:8], blue [7:0], and indexed pixels take their colour and local alpha from that entry.
- R3: The effective format is indexed when cfg_bpp is 2'b01 (8 bpp) or 2'b00, whatever cfg_fmt says. It is also indexed when cfg_fmt is 3'b000 or any code above 3'b100. Otherwise cfg_fmt selects 3'b001 = 5-6-5, 3'b010 = 5-5-5, 3'b011 = 4-4-4 and 3'b100 = 8-8-8-8, with cfg_bpp 2'b10 = 16 bpp and 2'b11 = 32 bpp.
- R4: An indexed pixel uses only in_word[7:0] as its index. The other bytes are padding and have no effect on the output.
- R5: A 5-6-5 pixel is in_word[15:11] red, [10:5] green and [4:0] blue. It carries no local alpha, so its local alpha is 255 even when local alpha is enabled.
- R6: With local alpha enabled, a 5-5-5 pixel (bit 15 spare; red [14:10], green [9:5], blue [4:0]) has local alpha 0 when bit 15 is 1 and 255 when it is 0. A 4-4-4 pixel (bits 15:12 spare; red [11:8], green [7:4], blue [3:0]) has local alpha 0 when any spare bit is 1 and 255 otherwise. With local alpha disabled the spare bits have no effect.
- R7: An 8-8-8-8 pixel uses the whole word: alpha [31:24], red [23:16], green [15:8], blue [7:0]. When cfg_lalpha_en is low, the local alpha of every format is 255.
- R8: A channel narrower than 8 bits is widened by repeating its top bits below it (5-bit x becomes {x, x[4:2]}, 6-bit becomes {x, x[5:4]}, 4-bit becomes {x, x}).
- R9: The effective alpha is round(local × global / 255), where global is cfg_galpha when cfg_galpha_en is high and 255 when it is low.
- R10: When cfg_key_en is high and the pixel matches the key, the effective alpha is 0. The match compares in_word[15:0] with cfg_key[15:0] for the 16-bit formats, the index in_word[7:0] with cfg_key[7:0] for indexed pixels, and in_word[23:0] with cfg_key[23:0] for 8-8-8-8.
- R11: Each output channel (out_pix and in_bg are {red, green, blue}, 8 bits each) equals round((a × overlay + (255 − a) × background) / 255).
- R12: With out_ready held high, a pixel accepted at one clock edge appears on out_valid/out_pix after the third edge. A cycle without an accepted pixel gives a cycle without out_valid three cycles later.
- R13: While out_valid is high and out_ready low, out_pix holds and in_ready is low. Pixels are neither dropped nor repeated, and they leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 3 | Colour format code |
| cfg_bpp | input | 2 | Container size code |
| cfg_lalpha_en | input | 1 | Enable per-pixel alpha |
| cfg_galpha_en | input | 1 | Enable global alpha |
| cfg_key_en | input | 1 | Enable colour key |
| cfg_key | input | 24 | Colour key value |
| cfg_galpha | input | 8 | Global alpha value |
| pal_idx_we | input | 1 | Load palette index from pal_wdata[7:0] |
| pal_data_we | input | 1 | Write pal_wdata to the indexed palette entry |
| pal_wdata | input | 32 | Palette write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_word | input | 32 | Raw overlay buffer word |
| in_bg | input | 24 | Background pixel {R,G,B} |
| out_valid | output | 1 | Blended pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_pix | output | 24 | Blended pixel {R,G,B} |

## Verification
The bench targets the points where format rules interact. It sets an 8 bpp container with a 5-6-5 format code and puts junk in the padding bytes; a design that honoured the code or used the padding would return the wrong colour. It sets spare bits in 5-5-5 and 4-4-4 words with local alpha both on and off; a design that ignored the switch, or applied it to 5-6-5, would show the overlay where the background belongs. It drives key matches whose upper half-word differs, and global alpha values of 0 and 255 on top of local alpha; a design that compared too many bits, or truncated instead of rounding, would miss by one level or fail to key. Random back-pressure checks that stalled outputs hold steady and that every pixel leaves exactly once.

// File: rtl/osd_comp_pkg.sv
package osd_comp_pkg;

  localparam int CH_W  = 8;
  localparam int N_CH  = 3;
  localparam int RGB_W = N_CH * CH_W;
  localparam int PIX_W = 32;
  localparam int PAL_W = 32;
  localparam int HW_W  = 16;
  localparam logic [CH_W-1:0] A_OPAQUE = '1;

  typedef enum logic [2:0] {
    FMT_INDEX    = 3'd0,
    FMT_RGB565   = 3'd1,
    FMT_RGB555   = 3'd2,
    FMT_RGB444   = 3'd3,
    FMT_ARGB8888 = 3'd4
  } fmt_e;

  typedef enum logic [1:0] {
    BPP_RSVD = 2'd0,
    BPP_8    = 2'd1,
    BPP_16   = 2'd2,
    BPP_32   = 2'd3
  } bpp_e;

  // Rounded division by 255 for products of two 8-bit values (p <= 65025).
  function automatic logic [CH_W-1:0] div255_rnd(input logic [15:0] p);
    logic [15:0] x;
    logic [15:0] y;
    x = p + 16'd128;
    y = x + {8'd0, x[15:8]};
    return y[15:8];
  endfunction

  // The 8 bpp container (and the reserved code) forces indexed decoding.
  function automatic fmt_e eff_fmt(input logic [1:0] bpp, input logic [2:0] code);
    if ((bpp == BPP_16 || bpp == BPP_32) && code >= 3'd1 && code <= 3'd4)
      return fmt_e'(code);
    return FMT_INDEX;
  endfunction

endpackage

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_we,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_we) idx_q <= wdata[AW-1:0];
  end

  // Single write port, registered read port: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (data_we) mem[idx_q] <= wdata;
    if (rd_en)   rd_data    <= mem[rd_addr];
  end

endmodule

// File: rtl/osd_px_decode.sv
module osd_px_decode
  import osd_comp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_vld,
  input  logic [PIX_W-1:0] word,
  input  logic [RGB_W-1:0] bg,
  input  logic [PAL_W-1:0] pal_entry,
  input  logic [2:0]       cfg_fmt,
  input  logic [1:0]       cfg_bpp,
  input  logic             lalpha_en,
  input  logic             galpha_en,
  input  logic             key_en,
  input  logic [RGB_W-1:0] key,
  input  logic [CH_W-1:0]  galpha,
  output logic             out_vld,
  output logic [RGB_W-1:0] ovl,
  output logic [CH_W-1:0]  alpha,
  output logic [RGB_W-1:0] bg_q
);

  fmt_e            fmt;
  logic [HW_W-1:0] hw;
  logic [CH_W-1:0] r, g, b;
  logic [CH_W-1:0] la_raw, la, ga, a_mix;
  logic            hit;

  assign fmt = eff_fmt(cfg_bpp, cfg_fmt);
  assign hw  = word[HW_W-1:0];

  always_comb begin
    r      = '0;
    g      = '0;
    b      = '0;
    la_raw = A_OPAQUE;
    hit    = 1'b0;
    unique case (fmt)
      FMT_RGB565: begin
        r   = {hw[15:11], hw[15:13]};
        g   = {hw[10:5],  hw[10:9]};
        b   = {hw[4:0],   hw[4:2]};
        hit = (hw == key[HW_W-1:0]);
      end
      FMT_RGB555: begin
        r      = {hw[14:10], hw[14:12]};
        g      = {hw[9:5],   hw[9:7]};
        b      = {hw[4:0],   hw[4:2]};
        la_raw = hw[15] ? '0 : A_OPAQUE;
        hit    = (hw == key[HW_W-1:0]);
      end
      FMT_RGB444: begin
        r      = {hw[11:8], hw[11:8]};
        g      = {hw[7:4],  hw[7:4]};
        b      = {hw[3:0],  hw[3:0]};
        la_raw = (|hw[15:12]) ? '0 : A_OPAQUE;
        hit    = (hw == key[HW_W-1:0]);
      end
      FMT_ARGB8888: begin
        r      = word[23:16];
        g      = word[15:8];
        b      = word[7:0];
        la_raw = word[31:24];
        hit    = (word[RGB_W-1:0] == key);
      end
      default: begin
        r      = pal_entry[23:16];
        g      = pal_entry[15:8];
        b      = pal_entry[7:0];
        la_raw = pal_entry[31:24];
        hit    = (word[7:0] == key[7:0]);
      end
    endcase
  end

  assign la    = lalpha_en ? la_raw : A_OPAQUE;
  assign ga    = galpha_en ? galpha : A_OPAQUE;
  assign a_mix = (key_en && hit) ? '0 : div255_rnd({8'd0, la} * {8'd0, ga});

  always_ff @(posedge clk) begin
    if (rst)     out_vld <= 1'b0;
    else if (en) out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      ovl   <= {r, g, b};
      alpha <= a_mix;
      bg_q  <= bg;
    end
  end

endmodule

// File: rtl/osd_blend.sv
module osd_blend
  import osd_comp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_vld,
  input  logic [RGB_W-1:0] ovl,
  input  logic [CH_W-1:0]  alpha,
  input  logic [RGB_W-1:0] bg,
  output logic             out_vld,
  output logic [RGB_W-1:0] out_pix
);

  logic [RGB_W-1:0] mix;
  logic [CH_W-1:0]  inv_a;

  assign inv_a = A_OPAQUE - alpha;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [15:0] fg_p, bg_p, sum;
    assign fg_p = {8'd0, alpha} * {8'd0, ovl[c*CH_W +: CH_W]};
    assign bg_p = {8'd0, inv_a} * {8'd0, bg[c*CH_W +: CH_W]};
    assign sum  = fg_p + bg_p;
    assign mix[c*CH_W +: CH_W] = div255_rnd(sum);
  end

  always_ff @(posedge clk) begin
    if (rst)     out_vld <= 1'b0;
    else if (en) out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (en) out_pix <= mix;
  end

endmodule

// File: rtl/osd_compositor.sv
module osd_compositor
  import osd_comp_pkg::*;
#(
  parameter int PAL_DEPTH = 256,
  localparam int PAL_AW   = $clog2(PAL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_fmt,
  input  logic [1:0]       cfg_bpp,
  input  logic             cfg_lalpha_en,
  input  logic             cfg_galpha_en,
  input  logic             cfg_key_en,
  input  logic [RGB_W-1:0] cfg_key,
  input  logic [CH_W-1:0]  cfg_galpha,
  input  logic             pal_idx_we,
  input  logic             pal_data_we,
  input  logic [PAL_W-1:0] pal_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_word,
  input  logic [RGB_W-1:0] in_bg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RGB_W-1:0] out_pix
);

  logic             pipe_en;
  logic             s1_vld;
  logic [PIX_W-1:0] s1_word;
  logic [RGB_W-1:0] s1_bg;
  logic [PAL_W-1:0] pal_q;
  logic             s2_vld;
  logic [RGB_W-1:0] s2_ovl;
  logic [CH_W-1:0]  s2_alpha;
  logic [RGB_W-1:0] s2_bg;

  // One enable for all stages: a held output freezes the whole pipe.
  assign pipe_en  = !out_valid || out_ready;
  assign in_ready = pipe_en;

  always_ff @(posedge clk) begin
    if (rst)          s1_vld <= 1'b0;
    else if (pipe_en) s1_vld <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (pipe_en) begin
      s1_word <= in_word;
      s1_bg   <= in_bg;
    end
  end

  osd_palette #(.DEPTH(PAL_DEPTH), .DW(PAL_W)) u_pal (
    .clk     (clk),
    .rst     (rst),
    .idx_we  (pal_idx_we),
    .data_we (pal_data_we),
    .wdata   (pal_wdata),
    .rd_en   (pipe_en),
    .rd_addr (in_word[PAL_AW-1:0]),
    .rd_data (pal_q)
  );

  osd_px_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .en        (pipe_en),
    .in_vld    (s1_vld),
    .word      (s1_word),
    .bg        (s1_bg),
    .pal_entry (pal_q),
    .cfg_fmt   (cfg_fmt),
    .cfg_bpp   (cfg_bpp),
    .lalpha_en (cfg_lalpha_en),
    .galpha_en (cfg_galpha_en),
    .key_en    (cfg_key_en),
    .key       (cfg_key),
    .galpha    (cfg_galpha),
    .out_vld   (s2_vld),
    .ovl       (s2_ovl),
    .alpha     (s2_alpha),
    .bg_q      (s2_bg)
  );

  osd_blend u_blend (
    .clk     (clk),
    .rst     (rst),
    .en      (pipe_en),
    .in_vld  (s2_vld),
    .ovl     (s2_ovl),
    .alpha   (s2_alpha),
    .bg      (s2_bg),
    .out_vld (out_valid),
    .out_pix (out_pix)
  );

endmodule

// File: rtl/osd_compositor_chk.sv
module osd_compositor_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_pix
);

  // R1: reset leaves no valid output behind
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  // R13: a stalled output holds its value
  p_stall_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R12: an accepted pixel emerges after three advancing edges
  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

  // R12: an empty input slot stays empty three cycles later
  p_bubble_r12: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) ##1 in_ready ##1 in_ready |=> !out_valid);

endmodule

bind osd_compositor osd_compositor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix)
);

// File: tb/test_osd_compositor.sv
module test_osd_compositor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_fmt = '0;
  logic [1:0]  cfg_bpp = 2'd1;
  logic        cfg_lalpha_en = 1'b0;
  logic        cfg_galpha_en = 1'b0;
  logic        cfg_key_en = 1'b0;
  logic [23:0] cfg_key = '0;
  logic [7:0]  cfg_galpha = '0;
  logic        pal_idx_we = 1'b0;
  logic        pal_data_we = 1'b0;
  logic [31:0] pal_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [23:0] in_bg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_pix;

  always #5 clk = ~clk;

  osd_compositor i_osd_compositor (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit stall_on = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R1";
  int unsigned pal_m [256];
  int unsigned pidx = 0;
  int unsigned exp_q[$];
  string       tag_q[$];
  int          t_q[$];
  bit          lat_q[$];
  bit          hold_pend = 1'b0;
  logic [23:0] hold_pix;

  function automatic int unsigned rnd255(int unsigned p);
    return (p + 127) / 255;
  endfunction

  function automatic int unsigned model_px(int unsigned w, int unsigned bg);
    int unsigned f, v, r, g, b, la, ga, a, ent, x, res;
    bit hit;
    f = ((cfg_bpp == 2 || cfg_bpp == 3) && cfg_fmt >= 1 && cfg_fmt <= 4) ? int'(cfg_fmt) : 0;
    v = w & 'hFFFF;
    hit = 0;
    la = 255;
    case (f)
      1: begin
        x = (v >> 11) & 31; r = (x << 3) | (x >> 2);
        x = (v >> 5) & 63;  g = (x << 2) | (x >> 4);
        x = v & 31;         b = (x << 3) | (x >> 2);
        hit = (v == (cfg_key & 'hFFFF));
      end
      2: begin
        x = (v >> 10) & 31; r = (x << 3) | (x >> 2);
        x = (v >> 5) & 31;  g = (x << 3) | (x >> 2);
        x = v & 31;         b = (x << 3) | (x >> 2);
        la = ((v >> 15) & 1) ? 0 : 255;
        hit = (v == (cfg_key & 'hFFFF));
      end
      3: begin
        r = ((v >> 8) & 15) * 17;
        g = ((v >> 4) & 15) * 17;
        b = (v & 15) * 17;
        la = ((v >> 12) != 0) ? 0 : 255;
        hit = (v == (cfg_key & 'hFFFF));
      end
      4: begin
        r = (w >> 16) & 255; g = (w >> 8) & 255; b = w & 255;
        la = w >> 24;
        hit = ((w & 'hFFFFFF) == cfg_key);
      end
      default: begin
        ent = pal_m[w & 255];
        r = (ent >> 16) & 255; g = (ent >> 8) & 255; b = ent & 255;
        la = ent >> 24;
        hit = ((w & 255) == (cfg_key & 255));
      end
    endcase
    if (!cfg_lalpha_en) la = 255;
    ga = cfg_galpha_en ? int'(cfg_galpha) : 255;
    a = (cfg_key_en && hit) ? 0 : rnd255(la * ga);
    res = rnd255(a * r + (255 - a) * ((bg >> 16) & 255)) << 16;
    res |= rnd255(a * g + (255 - a) * ((bg >> 8) & 255)) << 8;
    res |= rnd255(a * b + (255 - a) * (bg & 255));
    return res;
  endfunction

  // Monitor and reference model: everything here is stable at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (hold_pend) begin
        total++;
        if (!out_valid || out_pix !== hold_pix) begin
          bad++;
          $display("FAIL R13 stalled output changed: valid=%0b pix=%06h expected %06h",
                   out_valid, out_pix, hold_pix);
        end
      end
      hold_pend = out_valid && !out_ready;
      hold_pix  = out_pix;
      if (out_valid && out_ready) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R13 output with nothing pending: pix=%06h expected none", out_pix);
        end else begin
          int unsigned e;
          string tg;
          int t0;
          bit lc;
          e = exp_q.pop_front(); tg = tag_q.pop_front();
          t0 = t_q.pop_front(); lc = lat_q.pop_front();
          if (out_pix !== 24'(e)) begin
            bad++;
            $display("FAIL %s pixel: got %06h expected %06h", tg, out_pix, e);
          end
          if (lc) begin
            total++;
            if (cyc - t0 != 3) begin
              bad++;
              $display("FAIL R12 latency: got %0d expected 3", cyc - t0);
            end
          end
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model_px(in_word, in_bg));
        tag_q.push_back(cur_tag);
        t_q.push_back(cyc);
        lat_q.push_back(!stall_on);
      end
      if (pal_data_we) pal_m[pidx] = pal_wdata;
      if (pal_idx_we)  pidx = pal_wdata & 255;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic send_px(input logic [31:0] w, input logic [23:0] bg);
    in_word  = w;
    in_bg    = bg;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic pal_write(input int unsigned idx, input int unsigned val);
    @(posedge clk); #1;
    pal_idx_we = 1'b1; pal_wdata = 32'(idx);
    @(posedge clk); #1;
    pal_idx_we = 1'b0; pal_data_we = 1'b1; pal_wdata = 32'(val);
    @(posedge clk); #1;
    pal_data_we = 1'b0;
  endtask

  task automatic set_cfg(input int fmt, input int bpp, input bit la, input bit gen,
                         input int ga, input bit ken, input int unsigned key);
    @(posedge clk); #1;
    cfg_fmt = 3'(fmt); cfg_bpp = 2'(bpp); cfg_lalpha_en = la;
    cfg_galpha_en = gen; cfg_galpha = 8'(ga); cfg_key_en = ken; cfg_key = 24'(key);
  endtask

  task automatic rand_burst(input int n, input int unsigned mask, input int unsigned orv);
    for (int i = 0; i < n; i++)
      send_px((32'($urandom) & mask) | orv, 24'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    total += 2;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 in reset: out_valid=%0b in_ready=%0b expected 0/1", out_valid, in_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    total += 2;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 after reset: out_valid=%0b in_ready=%0b expected 0/1", out_valid, in_ready);
    end

    // R2: fill the palette; entry 0 transparent, entry 255 opaque
    for (int i = 0; i < 256; i++) begin
      int unsigned al;
      al = (i == 255) ? 255 : ((i * 53) & 255);
      pal_write(i, (al << 24) | ((i * 97 + 13) & 255) << 16 | ((i * 29 + 200) & 255) << 8 | ((i * 7) & 255));
    end

    // R3: 8 bpp with a 5-6-5 code still decodes indexed; upper bytes are junk
    cur_tag = "R3";
    set_cfg(1, 1, 1, 0, 0, 0, 0);
    rand_burst(20, 32'hFFFFFFFF, 0);
    send_px(32'hFFFF_FF00, 24'h123456);
    send_px(32'h0000_00FF, 24'h123456);
    drain();
    cur_tag = "R3";
    set_cfg(5, 2, 1, 0, 0, 0, 0);
    rand_burst(10, 32'hFFFFFFFF, 0);
    drain();
    // R4 / R2: 32 bpp indexed with padding bytes
    cur_tag = "R4";
    set_cfg(0, 3, 1, 0, 0, 0, 0);
    send_px(32'h0000_0042, 24'h808080);
    send_px(32'hDEAD_BE42, 24'h808080);
    rand_burst(15, 32'hFFFFFFFF, 0);
    drain();
    cur_tag = "R2";
    pal_write(8'h42, 32'hFF10_2030);
    set_cfg(0, 3, 1, 0, 0, 0, 0);
    send_px(32'hA5A5_A542, 24'h000000);
    drain();

    // R5 / R8: 5-6-5 with local alpha enabled has none
    cur_tag = "R5";
    set_cfg(1, 2, 1, 0, 0, 0, 0);
    send_px(32'h0000_FFFF, 24'h000000);
    send_px(32'h0000_0000, 24'hFFFFFF);
    drain();
    cur_tag = "R8";
    send_px(32'h0000_8410, 24'h000000);
    rand_burst(15, 32'hFFFFFFFF, 0);
    drain();

    // R6: spare-bit switches
    cur_tag = "R6";
    set_cfg(2, 2, 1, 0, 0, 0, 0);
    send_px(32'h0000_FFFF, 24'h0A0B0C);
    send_px(32'h0000_7FFF, 24'h0A0B0C);
    rand_burst(10, 32'hFFFFFFFF, 0);
    drain();
    set_cfg(3, 3, 1, 0, 0, 0, 0);
    send_px(32'h0000_1ABC, 24'h112233);
    send_px(32'h0000_8ABC, 24'h112233);
    send_px(32'h0000_0ABC, 24'h112233);
    rand_burst(10, 32'hFFFFFFFF, 0);
    drain();
    set_cfg(2, 2, 0, 0, 0, 0, 0);
    send_px(32'h0000_FFFF, 24'h0A0B0C);
    set_cfg(3, 2, 0, 0, 0, 0, 0);
    send_px(32'h0000_F123, 24'h0A0B0C);
    drain();

    // R7 / R9: 8-8-8-8 local alpha combined with global alpha
    cur_tag = "R7";
    set_cfg(4, 3, 1, 0, 0, 0, 0);
    send_px(32'h00FF_FFFF, 24'h102030);
    send_px(32'hFF00_0000, 24'h102030);
    send_px(32'h80C0_4020, 24'h6080A0);
    rand_burst(10, 32'hFFFFFFFF, 0);
    drain();
    set_cfg(4, 3, 0, 0, 0, 0, 0);
    send_px(32'h0012_3456, 24'hFEDCBA);
    drain();
    cur_tag = "R9";
    set_cfg(4, 3, 1, 1, 8'h9C, 0, 0);
    send_px(32'hFF40_80C0, 24'h000000);
    send_px(32'h7F40_80C0, 24'hFFFFFF);
    rand_burst(10, 32'hFFFFFFFF, 0);
    drain();
    set_cfg(4, 3, 1, 1, 0, 0, 0);
    send_px(32'hFFFF_FFFF, 24'h314159);
    set_cfg(1, 2, 0, 1, 255, 0, 0);
    send_px(32'h0000_F800, 24'h314159);
    set_cfg(0, 1, 1, 1, 8'h33, 0, 0);
    rand_burst(10, 32'hFFFFFFFF, 0);
    drain();

    // R10: colour key, including upper bits that must not take part
    cur_tag = "R10";
    set_cfg(1, 3, 1, 1, 200, 1, 24'h12F81F);
    send_px(32'hABCD_F81F, 24'h55AA33);
    send_px(32'hABCD_F81E, 24'h55AA33);
    set_cfg(4, 3, 1, 0, 0, 1, 24'h12F81F);
    send_px(32'hFF12_F81F, 24'h010203);
    send_px(32'hFF13_F81F, 24'h010203);
    set_cfg(0, 1, 0, 0, 0, 1, 24'h12F81F);
    send_px(32'hFFFF_FF1F, 24'h777777);
    send_px(32'h0000_0020, 24'h777777);
    set_cfg(3, 2, 1, 0, 0, 0, 24'h12F81F);
    send_px(32'h0000_F81F, 24'h777777);
    drain();

    // R11: general blending on random data
    cur_tag = "R11";
    set_cfg(4, 3, 1, 1, 8'hB7, 0, 0);
    rand_burst(30, 32'hFFFFFFFF, 0);
    drain();

    // R13: random back-pressure
    cur_tag = "R13";
    stall_on = 1'b1;
    rand_burst(60, 32'hFFFFFFFF, 0);
    set_cfg(2, 2, 1, 1, 8'h5A, 0, 0);
    rand_burst(40, 32'hFFFFFFFF, 0);
    drain();
    stall_on = 1'b0;
    repeat (3) @(posedge clk);
    #1;

    // R12: spaced pixels with out_ready high
    cur_tag = "R12";
    set_cfg(4, 3, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      send_px(32'($urandom), 24'($urandom));
      repeat (i) @(posedge clk);
      #1;
    end
    drain();

    repeat (5) @(negedge clk);
    total++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R13 leftover: pending=%0d valid=%0b expected 0/0", exp_q.size(), out_valid);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule